// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host half of an enhanced parallel port. A host issues single accesses over a small register interface. Offsets 3 and 4 are the two port registers that run peripheral cycles: offset 3 runs an address cycle and offset 4 runs a data cycle. Offset 2 holds an eight-bit control word. Offset 1 returns the peripheral status pins together with a sticky timeout flag.

Before any peripheral cycle starts, the engine compares the mode bits of the control word against a fixed pattern. A read needs one pattern and a write needs another. If the pattern does not match, the access finishes at once and no strobe moves. The data port also accepts 16-bit and 32-bit accesses. The engine moves these as a run of byte cycles, lowest byte first.

Every byte cycle is a four-phase handshake. The engine drives the strobe low and waits for the peripheral to raise its wait line. It then releases the strobe and waits for the wait line to fall. If either wait lasts longer than a parameterised limit, the engine releases the strobe, sets the timeout flag and drops any bytes still to be sent.

Top module: `epp_host_engine`

## Requirements
- R1: After reset the control register reads 0x0C, the timeout flag is 0, `host_ready` is 1, and both strobes and the write line are high.
- R2: A write to offset 3 or 4 runs cycles only when control bits {5,3,2,1,0} equal 0b00100 (only bit 2 set). Bits 7, 6 and 4 do not matter. Offset 3 produces one address-strobe byte cycle carrying wdata[7:0], with the write line low.
- R3: A write to offset 3 or 4 under any other control pattern completes with no strobe and no change to the timeout flag.
- R4: A read of offset 3 or 4 runs cycles only when control bits {5,3,2,1,0} equal 0b10100 (bits 5 and 2 set). Otherwise no strobe moves and the read returns 0xFFFFFFFF.
- R5: On offset 4, `host_size` 0 moves one byte, 1 moves two bytes and 2 or 3 moves four bytes. Bytes go out one data-strobe cycle each, least significant byte first. Offset 3 always moves one byte.
- R6: A permitted read places byte k taken from the peripheral into host_rdata bits [8k+7:8k]. Bytes not moved read as 0xFF.
- R7: If the wait line does not answer within WAIT_LIMIT clocks, the strobe is released, the timeout flag is set, the remaining bytes are skipped and unfilled read bytes stay 0xFF.
- R8: A read of offset 1 returns periph_status[7:1] in bits 7:1 and the timeout flag in bit 0.
- R9: Writing offset 1 with wdata[0]=1 clears the timeout flag. Writing it with wdata[0]=0 leaves the flag unchanged.
- R10: `host_ready` falls in the clock after an access is accepted. `host_done` is then a single-cycle pulse that marks the end of the access, with host_rdata valid in that cycle.
- R11: At most one of the two strobes is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when host_ready is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Register offset |
| host_size | input | 2 | Data-port width: 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Engine idle and able to take a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| periph_status | input | 7 | Peripheral status pins for status bits 7:1 |
| epp_data_out | output | 8 | Byte driven toward the peripheral |
| epp_data_oe | output | 1 | Output enable for epp_data_out |
| epp_data_in | input | 8 | Byte returned by the peripheral |
| epp_write_n | output | 1 | Active-low write indication |
| epp_astb_n | output | 1 | Active-low address strobe |
| epp_dstb_n | output | 1 | Active-low data strobe |
| epp_wait | input | 1 | Peripheral handshake response |

## Verification
The assertions assume the host offers a request only while `host_ready` is high, and that the control word stays fixed while a cycle runs. The control word cannot change mid-cycle because register writes are refused while the engine is busy. The bench keeps to both assumptions: its access task waits for `host_ready` and holds the request for exactly one clock. The peripheral model changes `epp_wait` and `epp_data_in` only on falling clock edges. It raises wait only while a strobe is low, and drops it once the strobe rises, unless it has been told to stay silent so that a timeout can be forced.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int unsigned HOST_BYTES = 4;
    localparam int unsigned HOST_W     = HOST_BYTES * 8;
    localparam int unsigned IDX_W      = $clog2(HOST_BYTES);

    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_ADDRP  = 3'd3;
    localparam logic [2:0] OFS_DATAP  = 3'd4;

    localparam logic [7:0] MODE_MASK  = 8'h2F;
    localparam logic [7:0] MODE_WRITE = 8'h04;
    localparam logic [7:0] MODE_READ  = 8'h24;
    localparam logic [7:0] CTRL_INIT  = 8'h0C;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RELEASE,
        PH_DONE
    } epp_phase_t;

    typedef struct packed {
        logic             is_write;
        logic             is_addr;
        logic [IDX_W-1:0] last_idx;
    } epp_job_t;

    function automatic logic [IDX_W-1:0] last_byte(input logic [1:0] size, input logic is_addr);
        if (is_addr) return '0;
        case (size)
            2'd0:    return IDX_W'(0);
            2'd1:    return IDX_W'(1);
            default: return IDX_W'(HOST_BYTES - 1);
        endcase
    endfunction

    function automatic logic mode_allows(input logic [7:0] ctrl, input logic is_write);
        return (ctrl & MODE_MASK) == (is_write ? MODE_WRITE : MODE_READ);
    endfunction

endpackage

// File: rtl/epp_ctrl_regs.sv
module epp_ctrl_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic       wr_status,
    input  logic [7:0] wbyte,
    input  logic       tmo_set,
    output logic [7:0] ctrl,
    output logic       tmo_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_INIT;
            tmo_flag <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= wbyte;
            if (tmo_set)
                tmo_flag <= 1'b1;
            else if (wr_status && wbyte[0])
                tmo_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
    import epp_pkg::*;
#(
    parameter int unsigned WAIT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  epp_job_t          job,
    input  logic [HOST_W-1:0] wdata,
    input  logic              epp_wait,
    input  logic [7:0]        epp_data_in,
    output logic              idle,
    output logic              done,
    output logic              tmo_set,
    output logic [HOST_W-1:0] rbuf,
    output logic [7:0]        epp_data_out,
    output logic              epp_data_oe,
    output logic              epp_write_n,
    output logic              epp_astb_n,
    output logic              epp_dstb_n
);
    epp_phase_t        phase_q;
    epp_job_t          job_q;
    logic [HOST_W-1:0] wbuf_q;
    logic [IDX_W-1:0]  idx_q;
    logic              timer_run;
    logic              expired;
    logic              in_cycle;

    assign timer_run = (phase_q == PH_STROBE  && !epp_wait) ||
                       (phase_q == PH_RELEASE &&  epp_wait);

    epp_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            job_q   <= '0;
            wbuf_q  <= '0;
            idx_q   <= '0;
            rbuf    <= '1;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    job_q   <= job;
                    wbuf_q  <= wdata;
                    idx_q   <= '0;
                    rbuf    <= '1;
                    phase_q <= PH_SETUP;
                end
                PH_SETUP: phase_q <= PH_STROBE;
                PH_STROBE: begin
                    if (epp_wait) begin
                        if (!job_q.is_write) rbuf[{idx_q, 3'b000} +: 8] <= epp_data_in;
                        phase_q <= PH_RELEASE;
                    end else if (expired) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_RELEASE: begin
                    if (!epp_wait) begin
                        if (idx_q == job_q.last_idx) begin
                            phase_q <= PH_DONE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            phase_q <= PH_SETUP;
                        end
                    end else if (expired) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign in_cycle     = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_RELEASE);
    assign idle         = (phase_q == PH_IDLE);
    assign done         = (phase_q == PH_DONE);
    assign tmo_set      = expired;
    assign epp_data_out = wbuf_q[{idx_q, 3'b000} +: 8];
    assign epp_data_oe  = in_cycle && job_q.is_write;
    assign epp_write_n  = !(in_cycle && job_q.is_write);
    assign epp_astb_n   = !(phase_q == PH_STROBE &&  job_q.is_addr);
    assign epp_dstb_n   = !(phase_q == PH_STROBE && !job_q.is_addr);
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_pkg::*;
#(
    parameter int unsigned WAIT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [2:0]        host_ofs,
    input  logic [1:0]        host_size,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [7:1]        periph_status,
    output logic [7:0]        epp_data_out,
    output logic              epp_data_oe,
    input  logic [7:0]        epp_data_in,
    output logic              epp_write_n,
    output logic              epp_astb_n,
    output logic              epp_dstb_n,
    input  logic              epp_wait
);
    logic [7:0]        ctrl_q;
    logic              tmo_flag;
    logic              tmo_set;
    logic              accept;
    logic              to_port;
    logic              seq_start;
    logic              seq_idle;
    logic              seq_done;
    logic [HOST_W-1:0] seq_rbuf;
    logic              local_done_q;
    logic              use_seq_q;
    logic [HOST_W-1:0] local_rdata_q;
    logic [HOST_W-1:0] local_rd;
    epp_job_t          job;

    assign accept    = host_req && host_ready;
    assign to_port   = (host_ofs == OFS_ADDRP) || (host_ofs == OFS_DATAP);
    assign seq_start = accept && to_port && mode_allows(ctrl_q, host_write);

    assign job.is_write = host_write;
    assign job.is_addr  = (host_ofs == OFS_ADDRP);
    assign job.last_idx = last_byte(host_size, host_ofs == OFS_ADDRP);

    epp_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (accept && host_write && host_ofs == OFS_CTRL),
        .wr_status (accept && host_write && host_ofs == OFS_STATUS),
        .wbyte     (host_wdata[7:0]),
        .tmo_set   (tmo_set),
        .ctrl      (ctrl_q),
        .tmo_flag  (tmo_flag)
    );

    epp_byte_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (seq_start),
        .job          (job),
        .wdata        (host_wdata),
        .epp_wait     (epp_wait),
        .epp_data_in  (epp_data_in),
        .idle         (seq_idle),
        .done         (seq_done),
        .tmo_set      (tmo_set),
        .rbuf         (seq_rbuf),
        .epp_data_out (epp_data_out),
        .epp_data_oe  (epp_data_oe),
        .epp_write_n  (epp_write_n),
        .epp_astb_n   (epp_astb_n),
        .epp_dstb_n   (epp_dstb_n)
    );

    always_comb begin
        case (host_ofs)
            OFS_STATUS: local_rd = {{(HOST_W-8){1'b0}}, periph_status, tmo_flag};
            OFS_CTRL:   local_rd = {{(HOST_W-8){1'b0}}, ctrl_q};
            default:    local_rd = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            local_done_q  <= 1'b0;
            use_seq_q     <= 1'b0;
            local_rdata_q <= '1;
        end else begin
            local_done_q <= accept && !seq_start;
            if (accept) begin
                use_seq_q     <= seq_start;
                local_rdata_q <= local_rd;
            end
        end
    end

    assign host_ready = seq_idle && !local_done_q;
    assign host_done  = seq_done || local_done_q;
    assign host_rdata = use_seq_q ? seq_rbuf : local_rdata_q;
endmodule

// File: rtl/epp_host_engine_sva.sv
module epp_host_engine_sva (
    input logic       clk,
    input logic       rst,
    input logic       host_req,
    input logic       host_ready,
    input logic       host_write,
    input logic [2:0] host_ofs,
    input logic       wbit0,
    input logic       epp_astb_n,
    input logic       epp_dstb_n,
    input logic       epp_write_n,
    input logic [7:0] ctrl_q,
    input logic       tmo_flag
);
    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !(!epp_astb_n && !epp_dstb_n));

    assert_write_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (($fell(epp_astb_n) || $fell(epp_dstb_n)) && !epp_write_n) |-> ((ctrl_q & 8'h2F) == 8'h04));

    assert_read_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (($fell(epp_astb_n) || $fell(epp_dstb_n)) && epp_write_n) |-> ((ctrl_q & 8'h2F) == 8'h24));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready) |=> !host_ready);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(tmo_flag) |-> $past(host_req && host_ready && host_write && host_ofs == 3'd1 && wbit0));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> $past(!host_ready));
endmodule

bind epp_host_engine epp_host_engine_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_write  (host_write),
    .host_ofs    (host_ofs),
    .wbit0       (host_wdata[0]),
    .epp_astb_n  (epp_astb_n),
    .epp_dstb_n  (epp_dstb_n),
    .epp_write_n (epp_write_n),
    .ctrl_q      (ctrl_q),
    .tmo_flag    (tmo_flag)
);

// File: tb/epp_host_engine_test.sv
module epp_host_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WLIM       = 8;

    typedef struct packed {
        logic       is_addr;
        logic       is_write;
        logic [7:0] data;
    } evt_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [2:0]  host_ofs = 3'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic        host_done;
    logic [31:0] host_rdata;
    logic [7:1]  periph_status = 7'h53;
    logic [7:0]  epp_data_out;
    logic        epp_data_oe;
    logic [7:0]  epp_data_in = 8'h00;
    logic        epp_write_n;
    logic        epp_astb_n;
    logic        epp_dstb_n;
    logic        epp_wait = 1'b0;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_req = "R1";
    evt_t  exp_q[$];

    int         resp_left = 1000000;
    int         resp_delay = 0;
    logic [7:0] rd_next = 8'h00;

    epp_host_engine #(.WAIT_LIMIT(WLIM)) uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
        .host_ofs(host_ofs), .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .periph_status(periph_status), .epp_data_out(epp_data_out),
        .epp_data_oe(epp_data_oe), .epp_data_in(epp_data_in),
        .epp_write_n(epp_write_n), .epp_astb_n(epp_astb_n),
        .epp_dstb_n(epp_dstb_n), .epp_wait(epp_wait)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Peripheral model and scoreboard monitor.
    initial begin
        bit seen = 0;
        bit alive = 0;
        int dly = 0;
        forever begin
            @(negedge clk);
            if (!epp_astb_n || !epp_dstb_n) begin
                if (!seen) begin
                    evt_t got;
                    seen = 1;
                    dly  = 0;
                    got.is_addr  = !epp_astb_n;
                    got.is_write = !epp_write_n;
                    got.data     = epp_write_n ? 8'h00 : epp_data_out;
                    if (exp_q.size() == 0) begin
                        check(0, cur_req, "unexpected strobe", {23'd0, got}, 32'h0);
                    end else begin
                        evt_t e;
                        e = exp_q.pop_front();
                        check(got == e, cur_req, "peripheral cycle", {23'd0, got}, {23'd0, e});
                        if (got.is_write) check(epp_data_oe, cur_req, "data drive enable", {31'd0, epp_data_oe}, 32'd1);
                    end
                    alive = (resp_left > 0);
                    if (alive) begin
                        resp_left--;
                        epp_data_in = rd_next;
                        rd_next = rd_next + 8'd1;
                    end
                end
                if (alive) begin
                    if (dly >= resp_delay) epp_wait = 1'b1;
                    else dly++;
                end
            end else begin
                seen = 0;
                epp_wait = 1'b0;
            end
        end
    end

    task automatic push(input logic a, input logic w, input logic [7:0] d);
        evt_t e;
        e.is_addr = a; e.is_write = w; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic access(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_write = wr; host_ofs = ofs; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        check(!host_ready, "R10", "ready after accept", {31'd0, host_ready}, 32'd0);
        while (!host_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(host_done, "R10", "done seen", {31'd0, host_done}, 32'd1);
        rd = host_rdata;
        @(negedge clk);
        check(!host_done && host_ready, "R10", "single done pulse",
              {30'd0, host_done, host_ready}, 32'd1);
        check(exp_q.size() == 0, cur_req, "cycles outstanding", exp_q.size(), 32'd0);
        exp_q.delete();
    endtask

    task automatic wr_reg(input logic [2:0] ofs, input logic [31:0] v);
        logic [31:0] d;
        access(1'b1, ofs, 2'd0, v, d);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        check(host_ready, "R1", "ready at reset", {31'd0, host_ready}, 32'd1);
        check(epp_astb_n && epp_dstb_n && epp_write_n, "R1", "lines idle",
              {29'd0, epp_astb_n, epp_dstb_n, epp_write_n}, 32'd7);
        access(1'b0, 3'd2, 2'd0, 0, rd);
        check(rd == 32'h0C, "R1", "control reset", rd, 32'h0C);
        cur_req = "R8";
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd == 32'hA6, "R8", "status at reset", rd, 32'hA6);

        cur_req = "R3";
        access(1'b1, 3'd3, 2'd0, 32'h55, rd);
        access(1'b1, 3'd4, 2'd2, 32'h12345678, rd);
        wr_reg(3'd2, 32'h24);
        access(1'b1, 3'd4, 2'd0, 32'h99, rd);
        wr_reg(3'd2, 32'h06);
        access(1'b1, 3'd3, 2'd0, 32'h99, rd);
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd[0] == 1'b0, "R3", "flag untouched by dropped writes", rd, 32'hA6);

        cur_req = "R2";
        wr_reg(3'd2, 32'h04);
        access(1'b0, 3'd2, 2'd0, 0, rd);
        check(rd == 32'h04, "R2", "control readback", rd, 32'h04);
        push(1, 1, 8'h5A);
        access(1'b1, 3'd3, 2'd2, 32'hFFFFFF5A, rd);
        wr_reg(3'd2, 32'hD4);
        push(0, 1, 8'h3C);
        access(1'b1, 3'd4, 2'd0, 32'h3C, rd);

        cur_req = "R5";
        push(0, 1, 8'hEF); push(0, 1, 8'hBE);
        access(1'b1, 3'd4, 2'd1, 32'h0000BEEF, rd);
        resp_delay = 3;
        push(0, 1, 8'h44); push(0, 1, 8'h33); push(0, 1, 8'h22); push(0, 1, 8'h11);
        access(1'b1, 3'd4, 2'd2, 32'h11223344, rd);
        resp_delay = 0;
        push(0, 1, 8'hD4); push(0, 1, 8'hC3); push(0, 1, 8'hB2); push(0, 1, 8'hA1);
        access(1'b1, 3'd4, 2'd3, 32'hA1B2C3D4, rd);

        cur_req = "R4";
        access(1'b0, 3'd4, 2'd2, 0, rd);
        check(rd == 32'hFFFFFFFF, "R4", "read refused in write mode", rd, 32'hFFFFFFFF);
        wr_reg(3'd2, 32'h2C);
        access(1'b0, 3'd3, 2'd0, 0, rd);
        check(rd == 32'hFFFFFFFF, "R4", "read refused with select", rd, 32'hFFFFFFFF);

        cur_req = "R6";
        wr_reg(3'd2, 32'h24);
        rd_next = 8'h70;
        push(1, 0, 8'h00);
        access(1'b0, 3'd3, 2'd2, 0, rd);
        check(rd == 32'hFFFFFF70, "R6", "address byte read", rd, 32'hFFFFFF70);
        rd_next = 8'h81;
        push(0, 0, 0); push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
        access(1'b0, 3'd4, 2'd2, 0, rd);
        check(rd == 32'h84838281, "R6", "word read order", rd, 32'h84838281);
        resp_delay = 2;
        push(0, 0, 0); push(0, 0, 0);
        access(1'b0, 3'd4, 2'd1, 0, rd);
        check(rd == 32'hFFFF8685, "R6", "half read", rd, 32'hFFFF8685);
        resp_delay = 0;

        cur_req = "R7";
        rd_next = 8'hA0;
        resp_left = 2;
        push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
        access(1'b0, 3'd4, 2'd2, 0, rd);
        check(rd == 32'hFFFFA1A0, "R7", "partial read after timeout", rd, 32'hFFFFA1A0);
        check(epp_dstb_n && epp_astb_n, "R7", "strobe released", {30'd0, epp_astb_n, epp_dstb_n}, 32'd3);
        cur_req = "R8";
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd == 32'hA7, "R8", "status shows timeout", rd, 32'hA7);

        cur_req = "R9";
        wr_reg(3'd1, 32'hFE);
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd == 32'hA7, "R9", "write 0 keeps flag", rd, 32'hA7);
        wr_reg(3'd1, 32'h01);
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd == 32'hA6, "R9", "write 1 clears flag", rd, 32'hA6);

        cur_req = "R7";
        wr_reg(3'd2, 32'h04);
        resp_left = 0;
        push(0, 1, 8'h34);
        access(1'b1, 3'd4, 2'd1, 32'h00001234, rd);
        resp_left = 1000000;
        access(1'b0, 3'd1, 2'd0, 0, rd);
        check(rd == 32'hA7, "R7", "write timeout sets flag", rd, 32'hA7);

        summary();
    end
endmodule